// File: doc/BRIEF.md
# In-Order Write Issue Gate

This block sits between a core's write path and the external bus. Every write the core produces arrives as a request carrying an address, data and a space code that marks it as a cache, memory or I/O write. The block queues the requests in a small FIFO, tags each one with a sequence number and hands them to the bus one at a time, in the order they were accepted. Because there is only one queue and one issue slot, a write of one space can never pass a write of another.

An external "write buffer drained" input, `ext_drained`, acts only as a brake. While it is low, no new write leaves the queue. A write already on the bus keeps its place until the bus accepts it. While it is high, writes still leave in acceptance order. Its level changes when writes go out, never the order they go out in. When the queue is full, `req_ready` drops and the core must hold its request.

Top module: `wr_order_gate`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `bus_valid` is 0 and `req_ready` is 1, and the first write accepted after reset carries sequence number 0.
- R2: Writes appear on the bus in exactly the order in which they were accepted (`req_valid` and `req_ready` both high at a clock edge), whatever their space codes (00 cache, 01 memory, 10 I/O, 11 passed through unchanged), with address, data and space unchanged.
- R3: Accepted writes are numbered 0, 1, 2, ... modulo 2^SEQ_W. Each write on the bus carries its number, so consecutive bus transfers carry numbers that step by exactly one.
- R4: A new write is placed on the bus (`bus_valid` rising, or a fresh write replacing one the bus just accepted) only at a clock edge where `ext_drained` is 1.
- R5: Once `bus_valid` is 1, it stays 1 with `bus_addr`, `bus_data`, `bus_space` and `bus_seq` held constant until the edge where `bus_ready` is 1, even if `ext_drained` falls meanwhile.
- R6: The queue holds DEPTH (default 4) writes that are not yet on the bus. With DEPTH writes queued, `req_ready` is 0 and a presented request is not accepted until a slot frees.
- R7: While `ext_drained` is 0, no queued write of any space, cache writes included, reaches the bus. All queued writes stay queued and leave in order once it returns to 1.
- R8: With the queue empty, the bus idle and `ext_drained` at 1, a write accepted at edge N shows `bus_valid` after edge N+1. With `bus_ready` and `ext_drained` held at 1, a continuous request stream moves one write per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core presents a write |
| req_ready | output | 1 | Queue can accept a write |
| req_addr | input | 32 | Write address |
| req_data | input | 32 | Write data |
| req_space | input | 2 | Space code: 00 cache, 01 memory, 10 I/O |
| ext_drained | input | 1 | External write buffer empty; low holds off new issue |
| bus_valid | output | 1 | A write is on the bus |
| bus_ready | input | 1 | Bus accepts the current write |
| bus_addr | output | 32 | Issued address |
| bus_data | output | 32 | Issued data |
| bus_space | output | 2 | Issued space code |
| bus_seq | output | 4 | Sequence number of the issued write |

## Verification
A single write into an idle gate measures issue latency. A back-to-back stream of mixed cache, memory and I/O writes, long enough to wrap the sequence counter, separates true in-order issue from any reordering or dropped numbering. Holding the drained input low while writes pile up to a full queue shows that the input stalls every space alike and that back-pressure stops acceptance at exactly DEPTH entries. Dropping the input while a write waits on a stalled bus shows that an issued write keeps its place while a later write stays held.

// File: rtl/wr_order_pkg.sv
package wr_order_pkg;

    parameter int unsigned WO_ADDR_W = 32;
    parameter int unsigned WO_DATA_W = 32;
    parameter int unsigned WO_SEQ_W  = 4;

    typedef enum logic [1:0] {
        SPACE_CACHE = 2'b00,
        SPACE_MEM   = 2'b01,
        SPACE_IO    = 2'b10,
        SPACE_OTHER = 2'b11
    } space_e;

    typedef struct packed {
        logic [WO_ADDR_W-1:0] addr;
        logic [WO_DATA_W-1:0] data;
        space_e               space;
        logic [WO_SEQ_W-1:0]  seq;
    } wr_item_t;

    function automatic logic [WO_SEQ_W-1:0] seq_step(input logic [WO_SEQ_W-1:0] cur);
        return cur + 1'b1;
    endfunction

endpackage

// File: rtl/wr_order_fifo.sv
module wr_order_fifo
    import wr_order_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  wr_item_t push_item,
    input  logic     pop,
    output wr_item_t head_item,
    output logic     full,
    output logic     empty
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    wr_item_t           slots [DEPTH];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [CNT_W-1:0]   count;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (count == CNT_W'(DEPTH));
    assign empty     = (count == '0);
    assign head_item = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && wr_ptr == PTR_W'(g)) slots[g] <= push_item;
        end
    end

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        push |-> !full)
        else $error("push into full queue");

    p_no_underflow_r2: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty)
        else $error("pop from empty queue");

    p_fill_level_r6: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> !empty)
        else $error("queue empty after a lone push");

endmodule

// File: rtl/wr_order_seq.sv
module wr_order_seq
    import wr_order_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                take,
    output logic [WO_SEQ_W-1:0] seq
);
    always_ff @(posedge clk) begin
        if (rst)       seq <= '0;
        else if (take) seq <= seq_step(seq);
    end

    p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
        take |=> seq == WO_SEQ_W'($past(seq) + 1'b1))
        else $error("sequence did not step on accept");

    p_seq_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(seq))
        else $error("sequence moved without accept");

endmodule

// File: rtl/wr_order_issue.sv
module wr_order_issue
    import wr_order_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     head_present,
    input  wr_item_t head_item,
    input  logic     drained,
    input  logic     bus_ready,
    output logic     take_head,
    output logic     bus_valid,
    output wr_item_t bus_item
);
    logic slot_free;

    assign slot_free = !bus_valid || bus_ready;
    assign take_head = head_present && drained && slot_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_valid <= 1'b0;
            bus_item  <= '0;
        end else if (take_head) begin
            bus_valid <= 1'b1;
            bus_item  <= head_item;
        end else if (bus_ready) begin
            bus_valid <= 1'b0;
        end
    end

    // checker state: number of the last write the bus accepted
    logic                last_ok;
    logic [WO_SEQ_W-1:0] last_seq;
    always_ff @(posedge clk) begin
        if (rst) begin
            last_ok  <= 1'b0;
            last_seq <= '0;
        end else if (bus_valid && bus_ready) begin
            last_ok  <= 1'b1;
            last_seq <= bus_item.seq;
        end
    end

    p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_item)))
        else $error("issued write changed before acceptance");

    p_gate_new_issue_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && (!$past(bus_valid) || $past(bus_ready))) |-> $past(drained))
        else $error("write issued while drained input low");

    p_order_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_ready && last_ok) |-> bus_item.seq == WO_SEQ_W'(last_seq + 1'b1))
        else $error("bus sequence out of order");

    p_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (!drained && !bus_valid) |=> !bus_valid)
        else $error("issue while held off");

endmodule

// File: rtl/wr_order_gate.sv
module wr_order_gate
    import wr_order_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [WO_ADDR_W-1:0] req_addr,
    input  logic [WO_DATA_W-1:0] req_data,
    input  logic [1:0]           req_space,
    input  logic                 ext_drained,
    output logic                 bus_valid,
    input  logic                 bus_ready,
    output logic [WO_ADDR_W-1:0] bus_addr,
    output logic [WO_DATA_W-1:0] bus_data,
    output logic [1:0]           bus_space,
    output logic [WO_SEQ_W-1:0]  bus_seq
);
    logic                accept, fifo_full, fifo_empty, take_head;
    logic [WO_SEQ_W-1:0] next_seq;
    wr_item_t            in_item, head_item, out_item;

    assign req_ready = !fifo_full;
    assign accept    = req_valid && !fifo_full;

    always_comb begin
        in_item.addr  = req_addr;
        in_item.data  = req_data;
        in_item.space = space_e'(req_space);
        in_item.seq   = next_seq;
    end

    wr_order_seq u_seq (
        .clk  (clk),
        .rst  (rst),
        .take (accept),
        .seq  (next_seq)
    );

    wr_order_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (accept),
        .push_item (in_item),
        .pop       (take_head),
        .head_item (head_item),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    wr_order_issue u_issue (
        .clk          (clk),
        .rst          (rst),
        .head_present (!fifo_empty),
        .head_item    (head_item),
        .drained      (ext_drained),
        .bus_ready    (bus_ready),
        .take_head    (take_head),
        .bus_valid    (bus_valid),
        .bus_item     (out_item)
    );

    assign bus_addr  = out_item.addr;
    assign bus_data  = out_item.data;
    assign bus_space = out_item.space;
    assign bus_seq   = out_item.seq;

    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (!bus_valid && req_ready))
        else $error("not idle after reset");

    p_backpressure_r6: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !bus_valid) |-> !take_head || ext_drained)
        else $error("take while full and held");

endmodule

// File: tb/test_wr_order_gate.sv
module test_wr_order_gate;
    localparam int SW = 4;
    localparam int QD = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_ready;
    logic [31:0] req_addr = '0, req_data = '0;
    logic [1:0]  req_space = '0;
    logic        ext_drained = 1'b1;
    logic        bus_valid, bus_ready = 1'b0;
    logic [31:0] bus_addr, bus_data;
    logic [1:0]  bus_space;
    logic [SW-1:0] bus_seq;

    int errors = 0, checks = 0;
    int sent = 0, got = 0;
    logic [31:0] q_addr [256];
    logic [31:0] q_data [256];
    logic [1:0]  q_space [256];
    logic [SW-1:0] q_seq [256];
    logic [SW-1:0] bench_seq = '0;
    logic prev_valid = 1'b0, prev_ready = 1'b0, prev_drained = 1'b0;
    logic [31:0] prev_addr = '0, prev_data = '0;
    logic [SW-1:0] prev_seq = '0;

    always #5 clk = ~clk;

    wr_order_gate #(.DEPTH(QD)) i_wr_order_gate (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_space(req_space),
        .ext_drained(ext_drained),
        .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_space(bus_space), .bus_seq(bus_seq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor at the falling edge: inputs and outputs are settled.
    always @(negedge clk) begin
        if (!rst) begin
            if (req_valid && req_ready) begin
                q_addr[sent % 256]  = req_addr;
                q_data[sent % 256]  = req_data;
                q_space[sent % 256] = req_space;
                q_seq[sent % 256]   = bench_seq;
                bench_seq = bench_seq + 1'b1;
                sent++;
            end
            if (bus_valid && (!prev_valid || prev_ready))
                chk(prev_drained, "R4", "new issue without drained", {31'd0, prev_drained}, 32'd1);
            if (prev_valid && !prev_ready) begin
                chk(bus_valid, "R5", "valid dropped before accept", {31'd0, bus_valid}, 32'd1);
                chk(bus_addr == prev_addr && bus_data == prev_data && bus_seq == prev_seq,
                    "R5", "held write changed", bus_addr, prev_addr);
            end
            if (bus_valid && bus_ready) begin
                if (got < sent) begin
                    chk(bus_addr == q_addr[got % 256] && bus_data == q_data[got % 256] &&
                        bus_space == q_space[got % 256], "R2", "order/content",
                        bus_addr, q_addr[got % 256]);
                    chk(bus_seq == q_seq[got % 256], "R3", "sequence", {28'd0, bus_seq},
                        {28'd0, q_seq[got % 256]});
                end else begin
                    chk(1'b0, "R2", "extra bus write", bus_addr, 32'd0);
                end
                got++;
            end
            prev_valid = bus_valid; prev_ready = bus_ready; prev_drained = ext_drained;
            prev_addr = bus_addr; prev_data = bus_data; prev_seq = bus_seq;
        end
    end

    task automatic after_edge();
        @(posedge clk); #1;
    endtask

    task automatic send(input logic [31:0] a, input logic [31:0] d, input logic [1:0] s);
        req_valid = 1'b1; req_addr = a; req_data = d; req_space = s;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        after_edge();
        req_valid = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while (got < sent && n < 500) begin after_edge(); n++; end
        chk(got == sent, "R2", "all writes delivered", got, sent);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) after_edge();
        chk(!bus_valid, "R1", "bus_valid in reset", {31'd0, bus_valid}, 32'd0);
        chk(req_ready, "R1", "req_ready in reset", {31'd0, req_ready}, 32'd1);
        rst = 1'b0;
        after_edge();
        chk(!bus_valid && req_ready, "R1", "idle after reset", {31'd0, bus_valid}, 32'd0);
    endtask

    task automatic t_latency();
        ext_drained = 1'b1; bus_ready = 1'b1;
        req_valid = 1'b1; req_addr = 32'h100; req_data = 32'hA0; req_space = 2'b01;
        @(negedge clk);
        chk(req_ready, "R8", "ready when empty", {31'd0, req_ready}, 32'd1);
        after_edge();
        req_valid = 1'b0;
        @(negedge clk);
        chk(!bus_valid, "R8", "not yet issued one edge after accept", {31'd0, bus_valid}, 32'd0);
        @(negedge clk);
        chk(bus_valid && bus_seq == 0, "R8", "issued two edges after accept (R1 seq 0)",
            {28'd0, bus_seq}, 32'd0);
        after_edge();
        drain();
    endtask

    task automatic t_stream();
        int t0, g0;
        ext_drained = 1'b1; bus_ready = 1'b1;
        g0 = got;
        for (int i = 0; i < 20; i++)
            send(32'h1000 + i * 4, 32'hC0DE0000 + i, 2'(i % 3));
        t0 = 0;
        while (got < sent && t0 < 50) begin after_edge(); t0++; end
        chk(got - g0 == 20, "R8", "stream delivered", got - g0, 20);
        chk(t0 <= 3, "R8", "one write per cycle tail", t0, 3);
        drain();
    endtask

    task automatic t_hold_off();
        ext_drained = 1'b0; bus_ready = 1'b1;
        send(32'h200, 32'h1, 2'b10);
        send(32'h204, 32'h2, 2'b00);
        send(32'h208, 32'h3, 2'b00);
        repeat (8) after_edge();
        chk(!bus_valid, "R7", "cache write held while not drained", {31'd0, bus_valid}, 32'd0);
        chk(got == sent - 3, "R7", "nothing delivered", got, sent - 3);
        ext_drained = 1'b1;
        drain();
    endtask

    task automatic t_inflight();
        ext_drained = 1'b1; bus_ready = 1'b0;
        send(32'h300, 32'h11, 2'b01);
        send(32'h304, 32'h12, 2'b00);
        @(negedge clk);
        chk(bus_valid && bus_addr == 32'h300, "R5", "first write on bus", bus_addr, 32'h300);
        after_edge();
        ext_drained = 1'b0;
        repeat (4) after_edge();
        @(negedge clk);
        chk(bus_valid && bus_addr == 32'h300, "R5", "issued write kept after drop", bus_addr, 32'h300);
        after_edge();
        bus_ready = 1'b1;
        after_edge();
        bus_ready = 1'b0;
        repeat (3) after_edge();
        @(negedge clk);
        chk(!bus_valid, "R4", "second write held after drop", {31'd0, bus_valid}, 32'd0);
        after_edge();
        ext_drained = 1'b1; bus_ready = 1'b1;
        drain();
    endtask

    task automatic t_full();
        int n;
        ext_drained = 1'b0; bus_ready = 1'b1;
        for (int i = 0; i < QD; i++) send(32'h400 + i, 32'h40 + i, 2'(i));
        @(negedge clk);
        chk(!req_ready, "R6", "ready low when full", {31'd0, req_ready}, 32'd0);
        req_valid = 1'b1; req_addr = 32'h4FF; req_data = 32'h4F; req_space = 2'b00;
        n = sent;
        repeat (5) after_edge();
        chk(sent == n, "R6", "request not accepted while full", sent, n);
        ext_drained = 1'b1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        after_edge();
        req_valid = 1'b0;
        drain();
        chk(sent == n + 1, "R6", "held request accepted later", sent, n + 1);
    endtask

    initial begin
        int cyc = 0;
        fork
            begin
                t_reset();
                t_latency();
                t_stream();
                t_hold_off();
                t_inflight();
                t_full();
            end
            begin
                while (cyc < 100000) begin @(posedge clk); cyc++; end
                errors++; checks++;
                $display("FAIL watchdog expired: actual=%0d expected=<%0d", cyc, 100000);
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule